// File: doc/BRIEF.md
# Serial Control and Calibration Register Port

This block is the register side of a converter-style peripheral. A host reaches it through a synchronous serial interface. Each transfer is framed by an active-low frame input. Bits travel MSB first and are taken on rising edges of a serial clock. A direction input, sampled when the frame opens, marks the transfer as a read or a write. The serial lines are sampled in the block's system-clock domain, so the serial clock must run well below the system clock.

An address-select input, also sampled when the frame opens, picks the target. With select low, the target is the 24-bit control word. With select high, the target depends on the mode field of the control word:

- Mode 110 selects the zero-scale calibration coefficient of the selected channel.
- Mode 111 selects the full-scale calibration coefficient of the selected channel.
- Any other mode selects the conversion result, which can be read but not written.

The control word is decoded continuously into mode, gain, channel, word-length, excitation, burn-out, polarity and filter-code outputs. The coefficient pair of the active channel is presented to the front end. A calibration sequencer can return the mode field to normal through a clear input.

Top module: `ser_ctrl_port`

## Requirements
- R1: A write frame with select low that delivers 24 serial bits replaces the control word. A read frame with select low returns the 24-bit control word on `sdo`, MSB first.
- R2: The control word decodes as follows. Bits 23:21 are the mode, 20:18 the gain code, 17:16 the channel, bit 15 word length, bit 14 excitation enable, bit 13 burn-out enable, bit 12 unipolar (0 = bipolar), and 11:0 the filter code. `gain_mult` equals 2 to the power of the gain code, from 1 to 128.
- R3: A write frame that closes after fewer than 24 rising serial-clock edges leaves the control word unchanged.
- R4: Serial-clock edges after the 24th in a frame are ignored. A write commits only the first 24 bits, and a read drives `sdo` low after its last bit.
- R5: With select high, mode 110 reads or writes the zero-scale coefficient and mode 111 the full-scale coefficient of the channel in bits 17:16. These transfers are always 24 bits, and a write of fewer than 24 bits is discarded. Channel code 11 addresses no storage: writes to it are dropped and reads of it return zero.
- R6: With select high in a mode other than 110 or 111, a read returns the conversion result. If word length is 0, the read is 16 bits (`conv_data[23:16]` first, then `conv_data[15:8]`), followed by zeros. If word length is 1, all 24 bits are returned.
- R7: After reset, the control word and every coefficient are zero, which gives normal mode, gain 1, channel 00, 16-bit words, excitation off, burn-out off and bipolar.
- R8: A select-high write in a mode other than 110 or 111 changes neither the control word nor any coefficient.
- R9: A one-cycle pulse on `mode_clr` sets the mode field to 000 on the next clock and leaves the other control bits unchanged. A control-word write frame in progress during the pulse still commits its full 24-bit word.
- R10: `sdo` is low whenever no read frame is open, including throughout write frames.
- R11: `zs_coef` and `fs_coef` continuously show the stored coefficients of the channel selected in the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Active-low transfer frame |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial write data, MSB first |
| sdo | output | 1 | Serial read data, MSB first |
| sel | input | 1 | Address select: 0 = control word, 1 = data/coefficients |
| xfer_rd | input | 1 | Transfer direction: 1 = read, 0 = write |
| conv_data | input | 24 | Conversion result from the front end |
| mode_clr | input | 1 | Sequencer request to return the mode field to 000 |
| mode | output | 3 | Mode field |
| gain_code | output | 3 | Gain code |
| gain_mult | output | 8 | Decoded gain, 2 to the power of gain_code |
| chan | output | 2 | Selected channel |
| wide_word | output | 1 | Word length: 0 = 16 bit, 1 = 24 bit |
| rtd_en | output | 1 | Excitation current enable |
| burnout_en | output | 1 | Burn-out current enable |
| unipolar | output | 1 | Unipolar input range when 1 |
| filt_code | output | 12 | Filter code |
| zs_coef | output | 24 | Zero-scale coefficient of the selected channel |
| fs_coef | output | 24 | Full-scale coefficient of the selected channel |

## Verification
On every cycle the assertions check the following. The control word holds unless a commit or a clear occurs. A clear zeroes only the mode bits. Coefficients change only on a coefficient write. The bit counter never passes 24 and a commit is a single pulse. `sdo` stays quiet outside a read frame. The bench scenarios show what no single-cycle property can:

- that partial frames and surplus clocks leave exactly the right value behind;
- that each channel and bank is addressed correctly, across a sweep of all gain codes, channels and both word lengths;
- that a clear in the middle of a frame leaves the frame's word intact.

// File: rtl/scr_pkg.sv
// Shared definitions for the serial control/calibration port.
// Assumes a 24-bit control word with the field order below.
package scr_pkg;
    localparam int WORD_W  = 24;
    localparam int SHORT_W = 16;
    localparam int NUM_CH  = 3;
    localparam int CH_W    = 2;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    localparam logic [2:0] MODE_NORMAL = 3'b000;
    localparam logic [2:0] MODE_ZS     = 3'b110;
    localparam logic [2:0] MODE_FS     = 3'b111;

    // Control word layout, MSB first.
    typedef struct packed {
        logic [2:0]  mode;
        logic [2:0]  gain;
        logic [1:0]  chan;
        logic        wide;
        logic        rtd;
        logic        bo;
        logic        uni;
        logic [11:0] filt;
    } ctrl_t;

    // Destination of a frame, fixed when the frame opens.
    typedef enum logic [1:0] {
        TGT_CTRL = 2'd0,
        TGT_ZS   = 2'd1,
        TGT_FS   = 2'd2,
        TGT_DATA = 2'd3
    } tgt_t;
endpackage

// File: rtl/scr_shifter.sv
// Serial frame engine. Detects frame opening and rising serial-clock edges
// in the clk domain. Shifts write bits in and read bits out, counts up to W
// edges and ignores the rest. Issues one commit pulse when a write frame
// reaches W bits.
// Assumes sclk and frame_n are already synchronous to clk and slow enough
// that each sclk level lasts at least one clk period.
module scr_shifter #(
    parameter int W     = 24,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             sclk,
    input  logic             sdi,
    input  logic             rd_req,
    input  logic [1:0]       tag_in,
    input  logic [W-1:0]     ld_word,
    input  logic [CNT_W-1:0] ld_len,
    output logic             sdo,
    output logic             wr_done,
    output logic [W-1:0]     wr_word,
    output logic [1:0]       tag_q
);
    logic             sclk_q, frame_q, in_frame, rd_q, done_q;
    logic [CNT_W-1:0] cnt, len_q;
    logic [W-1:0]     in_sr, out_sr;
    logic             start, sclk_rise, take;

    // Edge detection for frame opening and serial-clock rise.
    always_comb begin
        start     = frame_q & ~frame_n;
        sclk_rise = sclk & ~sclk_q;
        take      = in_frame & ~frame_n & sclk_rise & (cnt < CNT_W'(W));
    end

    // Frame state, bit counter and the two shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            frame_q  <= 1'b1;
            in_frame <= 1'b0;
            rd_q     <= 1'b0;
            done_q   <= 1'b0;
            cnt      <= '0;
            len_q    <= '0;
            in_sr    <= '0;
            out_sr   <= '0;
            tag_q    <= '0;
        end else begin
            sclk_q  <= sclk;
            frame_q <= frame_n;
            done_q  <= 1'b0;
            if (start) begin
                in_frame <= 1'b1;
                cnt      <= '0;
                rd_q     <= rd_req;
                out_sr   <= ld_word;
                len_q    <= ld_len;
                tag_q    <= tag_in;
                in_sr    <= '0;
            end else begin
                if (frame_n) in_frame <= 1'b0;
                if (take) begin
                    in_sr  <= {in_sr[W-2:0], sdi};
                    out_sr <= {out_sr[W-2:0], 1'b0};
                    cnt    <= cnt + 1'b1;
                    if (!rd_q && cnt == CNT_W'(W - 1)) done_q <= 1'b1;
                end
            end
        end
    end

    // Read data appears only inside an open read frame and within its length.
    always_comb begin
        sdo     = (in_frame && !frame_n && rd_q && cnt < len_q) ? out_sr[W-1] : 1'b0;
        wr_done = done_q;
        wr_word = in_sr;
    end

    assert_cnt_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(W));
    assert_single_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    assert_sdo_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_n |=> !sdo);
endmodule

// File: rtl/scr_ctrl.sv
// Control word register. Loads a full word on a commit pulse. Otherwise a
// clear request zeroes the mode bits. Otherwise it holds.
// Assumes the commit pulse only arrives after a complete 24-bit frame.
module scr_ctrl #(
    parameter int W      = 24,
    parameter int MODE_W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_word,
    input  logic         clr,
    output logic [W-1:0] ctrl_q
);
    localparam int REST_W = W - MODE_W;

    // Control word update; a committing write takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wr_word;
        else if (clr)   ctrl_q <= {{MODE_W{1'b0}}, ctrl_q[REST_W-1:0]};
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr) |=> $stable(ctrl_q));
    assert_clear_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr_en) |=> (ctrl_q[W-1:REST_W] == '0));
    assert_clear_keeps_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr_en) |=> $stable(ctrl_q[REST_W-1:0]));
endmodule

// File: rtl/scr_coef.sv
// Calibration coefficient bank: one zero-scale and one full-scale word per
// channel. Write channels at or above NUM_CH are dropped, and reads of them
// return zero.
module scr_coef #(
    parameter int W      = 24,
    parameter int NUM_CH = 3,
    parameter int CH_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic            sel_fs,
    input  logic [CH_W-1:0] wch,
    input  logic [W-1:0]    wdata,
    input  logic [CH_W-1:0] rch,
    output logic [W-1:0]    zs_rd,
    output logic [W-1:0]    fs_rd
);
    logic [NUM_CH-1:0][W-1:0] zs_q, fs_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // Per-channel storage for both coefficient words.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                zs_q[g] <= '0;
                fs_q[g] <= '0;
            end else if (we && wch == CH_W'(g)) begin
                if (sel_fs) fs_q[g] <= wdata;
                else        zs_q[g] <= wdata;
            end
        end
    end

    // Read selection for the addressed channel.
    always_comb begin
        zs_rd = '0;
        fs_rd = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rch == CH_W'(i)) begin
                zs_rd = zs_q[i];
                fs_rd = fs_q[i];
            end
        end
    end

    assert_coef_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(zs_q) && $stable(fs_q)));
    assert_bad_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wch >= CH_W'(NUM_CH)) |=> ($stable(zs_q) && $stable(fs_q)));
endmodule

// File: rtl/ser_ctrl_port.sv
// Top of the serial control/calibration port. Chooses the frame target from
// the select input and the mode field, feeds the frame engine with the word
// to read, routes committed writes, and decodes the control word.
// Assumes the channel field does not change during a coefficient frame.
module ser_ctrl_port
    import scr_pkg::*;
#(
    parameter int NUM_CHAN = NUM_CH,
    parameter int SHORT_LEN = SHORT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_n,
    input  logic                   sclk,
    input  logic                   sdi,
    output logic                   sdo,
    input  logic                   sel,
    input  logic                   xfer_rd,
    input  logic [WORD_W-1:0]      conv_data,
    input  logic                   mode_clr,
    output logic [2:0]             mode,
    output logic [2:0]             gain_code,
    output logic [(1<<3)-1:0]      gain_mult,
    output logic [CH_W-1:0]        chan,
    output logic                   wide_word,
    output logic                   rtd_en,
    output logic                   burnout_en,
    output logic                   unipolar,
    output logic [11:0]            filt_code,
    output logic [WORD_W-1:0]      zs_coef,
    output logic [WORD_W-1:0]      fs_coef
);
    localparam int PAD_W = WORD_W - SHORT_LEN;
    localparam int GM_W  = 1 << 3;

    logic [WORD_W-1:0] ctrl_q, wr_word, ld_word;
    logic [CNT_W-1:0]  ld_len;
    logic [1:0]        tag_q;
    ctrl_t             cw;
    tgt_t              tgt, tgt_q;
    logic              wr_done, ctrl_we, coef_we;

    // Field decode of the stored control word.
    always_comb begin
        cw         = ctrl_t'(ctrl_q);
        mode       = cw.mode;
        gain_code  = cw.gain;
        gain_mult  = GM_W'(1) << cw.gain;
        chan       = cw.chan;
        wide_word  = cw.wide;
        rtd_en     = cw.rtd;
        burnout_en = cw.bo;
        unipolar   = cw.uni;
        filt_code  = cw.filt;
    end

    // Target selection and read-word preparation for a frame about to open.
    always_comb begin
        if (!sel)                 tgt = TGT_CTRL;
        else if (cw.mode == MODE_ZS) tgt = TGT_ZS;
        else if (cw.mode == MODE_FS) tgt = TGT_FS;
        else                      tgt = TGT_DATA;
        ld_len = CNT_W'(WORD_W);
        case (tgt)
            TGT_CTRL: ld_word = ctrl_q;
            TGT_ZS:   ld_word = zs_coef;
            TGT_FS:   ld_word = fs_coef;
            default: begin
                if (cw.wide) ld_word = conv_data;
                else begin
                    ld_word = {conv_data[WORD_W-1:PAD_W], {PAD_W{1'b0}}};
                    ld_len  = CNT_W'(SHORT_LEN);
                end
            end
        endcase
    end

    // Write routing by the target latched at frame opening.
    always_comb begin
        tgt_q   = tgt_t'(tag_q);
        ctrl_we = wr_done && (tgt_q == TGT_CTRL);
        coef_we = wr_done && (tgt_q == TGT_ZS || tgt_q == TGT_FS);
    end

    scr_shifter #(.W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sclk(sclk), .sdi(sdi),
        .rd_req(xfer_rd), .tag_in(tgt), .ld_word(ld_word), .ld_len(ld_len),
        .sdo(sdo), .wr_done(wr_done), .wr_word(wr_word), .tag_q(tag_q)
    );

    scr_ctrl #(.W(WORD_W), .MODE_W(3)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctrl_we), .wr_word(wr_word),
        .clr(mode_clr), .ctrl_q(ctrl_q)
    );

    scr_coef #(.W(WORD_W), .NUM_CH(NUM_CHAN), .CH_W(CH_W)) u_coef (
        .clk(clk), .rst_n(rst_n), .we(coef_we), .sel_fs(tgt_q == TGT_FS),
        .wch(cw.chan), .wdata(wr_word), .rch(cw.chan),
        .zs_rd(zs_coef), .fs_rd(fs_coef)
    );

    assert_data_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && tgt_q == TGT_DATA) |=> ($stable(ctrl_q) && $stable(zs_coef) && $stable(fs_coef)));
    assert_gain_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gain_mult) && gain_mult != '0);
endmodule

// File: tb/ser_ctrl_port_test.sv
module ser_ctrl_port_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic frame_n = 1'b1, sclk = 1'b0, sdi = 1'b0, sel = 1'b0, xfer_rd = 1'b0, mode_clr = 1'b0;
    logic [23:0] conv_data = 24'h000000;
    logic sdo, wide_word, rtd_en, burnout_en, unipolar;
    logic [2:0] mode, gain_code;
    logic [7:0] gain_mult;
    logic [1:0] chan;
    logic [11:0] filt_code;
    logic [23:0] zs_coef, fs_coef;
    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    bit sdo_seen;

    always #5 clk = ~clk;

    ser_ctrl_port uut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
        .sel(sel), .xfer_rd(xfer_rd), .conv_data(conv_data), .mode_clr(mode_clr),
        .mode(mode), .gain_code(gain_code), .gain_mult(gain_mult), .chan(chan),
        .wide_word(wide_word), .rtd_en(rtd_en), .burnout_en(burnout_en),
        .unipolar(unipolar), .filt_code(filt_code), .zs_coef(zs_coef), .fs_coef(fs_coef)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [23:0] mk(input logic [2:0] md, input logic [2:0] g,
        input logic [1:0] ch, input logic wl, input logic [11:0] fc);
        return {md, g, ch, wl, 1'b0, 1'b0, 1'b0, fc};
    endfunction

    // Write frame: nbits of w, MSB first; records whether sdo ever rose.
    task automatic wr_frame(input logic s, input logic [31:0] w, input int nbits);
        sdo_seen = 0;
        sel = s; xfer_rd = 1'b0; frame_n = 1'b0;
        tick(2);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0; sdi = (i < 32) ? w[31 - i] : 1'b0;
            tick(2);
            if (sdo) sdo_seen = 1;
            sclk = 1'b1; tick(2);
            if (sdo) sdo_seen = 1;
        end
        sclk = 1'b0; tick(2);
        frame_n = 1'b1; tick(3);
    endtask

    // Read frame of nbits; bit i lands in r[nbits-1-i].
    task automatic rd_frame(input logic s, input int nbits, output logic [31:0] r);
        r = '0;
        sel = s; xfer_rd = 1'b1; frame_n = 1'b0;
        tick(2);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0; tick(2);
            r[nbits - 1 - i] = sdo;
            sclk = 1'b1; tick(2);
        end
        sclk = 1'b0; tick(2);
        frame_n = 1'b1; xfer_rd = 1'b0; tick(3);
    endtask

    function automatic logic [23:0] cur_ctrl();
        return {mode, gain_code, chan, wide_word, rtd_en, burnout_en, unipolar, filt_code};
    endfunction

    initial begin
        logic [31:0] r;
        logic [23:0] w, v;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R7 reset state
        chk("R7 ctrl", {8'h0, cur_ctrl()}, 32'h0);
        chk("R7 gain_mult", {24'h0, gain_mult}, 32'd1);
        chk("R7 zs", {8'h0, zs_coef}, 32'h0);
        chk("R7 fs", {8'h0, fs_coef}, 32'h0);
        chk("R10 idle sdo", {31'h0, sdo}, 32'h0);

        // R1/R2 full write, field decode, readback
        w = 24'hB6_E5A7;
        wr_frame(1'b0, {w, 8'h00}, 24);
        chk("R1 write", {8'h0, cur_ctrl()}, {8'h0, w});
        chk("R10 sdo in write", {31'h0, sdo_seen}, 32'h0);
        chk("R2 mode", {29'h0, mode}, {29'h0, w[23:21]});
        chk("R2 gain", {29'h0, gain_code}, {29'h0, w[20:18]});
        chk("R2 chan", {30'h0, chan}, {30'h0, w[17:16]});
        chk("R2 flags", {28'h0, wide_word, rtd_en, burnout_en, unipolar}, {28'h0, w[15:12]});
        chk("R2 filt", {20'h0, filt_code}, {20'h0, w[11:0]});
        rd_frame(1'b0, 24, r);
        chk("R1 readback", r, {8'h0, w});

        // R2 gain sweep
        for (int g = 0; g < 8; g++) begin
            wr_frame(1'b0, {mk(3'b000, 3'(g), 2'd1, 1'b0, 12'(19 + g)), 8'h00}, 24);
            chk("R2 gain_mult", {24'h0, gain_mult}, 32'd1 << g);
        end

        // R3 partial write
        w = cur_ctrl();
        wr_frame(1'b0, 32'hFFFF_FFFF, 12);
        chk("R3 partial", {8'h0, cur_ctrl()}, {8'h0, w});
        wr_frame(1'b0, 32'h0, 23);
        chk("R3 23 bits", {8'h0, cur_ctrl()}, {8'h0, w});

        // R4 surplus clocks: 30-bit write keeps the first 24
        wr_frame(1'b0, {24'h5A_3C0F, 8'hFF}, 30);
        chk("R4 extra write", {8'h0, cur_ctrl()}, 32'h005A_3C0F);
        rd_frame(1'b0, 28, r);
        chk("R4 extra read", r, {4'h0, 24'h5A_3C0F, 4'h0});

        // R5/R11 coefficient sweep over channels
        for (int c = 0; c < 3; c++) begin
            v = 24'h13579B ^ (24'(c) * 24'h010101);
            wr_frame(1'b0, {mk(3'b110, 3'd0, 2'(c), 1'b0, 12'd60), 8'h0}, 24);
            wr_frame(1'b1, {v, 8'h0}, 24);
            wr_frame(1'b0, {mk(3'b111, 3'd0, 2'(c), 1'b0, 12'd60), 8'h0}, 24);
            wr_frame(1'b1, {~v, 8'h0}, 24);
            wr_frame(1'b1, 32'h0, 10);   // partial, must be dropped
            rd_frame(1'b1, 24, r);
            chk("R5 fs read", r, {8'h0, ~v});
            wr_frame(1'b0, {mk(3'b110, 3'd0, 2'(c), 1'b1, 12'd60), 8'h0}, 24);
            rd_frame(1'b1, 24, r);
            chk("R5 zs read wl1", r, {8'h0, v});
            wr_frame(1'b0, {mk(3'b000, 3'd0, 2'(c), 1'b0, 12'd60), 8'h0}, 24);
            chk("R11 zs out", {8'h0, zs_coef}, {8'h0, v});
            chk("R11 fs out", {8'h0, fs_coef}, {8'h0, ~v});
        end
        // R5 channel 11
        wr_frame(1'b0, {mk(3'b110, 3'd0, 2'd3, 1'b0, 12'd60), 8'h0}, 24);
        wr_frame(1'b1, 32'hABCD_EF00, 24);
        rd_frame(1'b1, 24, r);
        chk("R5 chan3 read", r, 32'h0);
        wr_frame(1'b0, {mk(3'b110, 3'd0, 2'd0, 1'b0, 12'd60), 8'h0}, 24);
        chk("R5 chan3 no alias", {8'h0, zs_coef}, {8'h0, 24'h13579B});

        // R6 data reads, both word lengths
        conv_data = 24'hC3_96A5;
        wr_frame(1'b0, {mk(3'b000, 3'd0, 2'd0, 1'b0, 12'd60), 8'h0}, 24);
        rd_frame(1'b1, 24, r);
        chk("R6 16-bit", r, 32'h00C3_9600);
        wr_frame(1'b0, {mk(3'b101, 3'd0, 2'd0, 1'b1, 12'd60), 8'h0}, 24);
        rd_frame(1'b1, 24, r);
        chk("R6 24-bit", r, 32'h00C3_96A5);

        // R8 select-high write in a non-coefficient mode is dropped
        w = cur_ctrl();
        wr_frame(1'b1, 32'h1234_5600, 24);
        chk("R8 ctrl", {8'h0, cur_ctrl()}, {8'h0, w});
        chk("R8 zs", {8'h0, zs_coef}, {8'h0, 24'h13579B});

        // R9 clear pulse
        wr_frame(1'b0, {mk(3'b101, 3'd4, 2'd2, 1'b1, 12'd99), 8'h0}, 24);
        w = cur_ctrl();
        mode_clr = 1'b1; tick(1); mode_clr = 1'b0;
        chk("R9 cleared", {8'h0, cur_ctrl()}, {8'h0, 3'b000, w[20:0]});
        // R9 clear during a write frame
        w = mk(3'b011, 3'd2, 2'd1, 1'b0, 12'd777);
        sel = 1'b0; xfer_rd = 1'b0; frame_n = 1'b0; tick(2);
        for (int i = 0; i < 24; i++) begin
            sclk = 1'b0; sdi = w[23 - i];
            if (i == 10) mode_clr = 1'b1;
            tick(1); mode_clr = 1'b0; tick(1);
            sclk = 1'b1; tick(2);
        end
        sclk = 1'b0; tick(2); frame_n = 1'b1; tick(3);
        chk("R9 frame intact", {8'h0, cur_ctrl()}, {8'h0, w});

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule